// File: doc/BRIEF.md
# Virtual-8086 Segment and Page Address Translator

This block turns the segment:offset pair of a task running in virtual-8086 mode into a physical address. It shifts the 16-bit segment left by four bits and adds the 16-bit offset. The result is a 20-bit linear address that wraps within 1 MB. When paging is on, the upper 8 linear bits select one of 256 entries in a page table. That entry supplies a 20-bit frame number. The lower 12 bits pass through unchanged, which gives a 32-bit physical address anywhere in 4 GB.

The page table is loaded through a write port while the task switch runs. Each virtual-8086 task can therefore get its own mapping of its 1 MB space, and several tasks may point pages at the same frame to share code. A lookup that lands on an entry whose present bit is clear returns a fault instead of a valid address. Every request is answered one clock after it is presented.

Top module: `v86_xlate`

## Requirements
- R1: With paging off, the physical address is the 20-bit linear address `(seg << 4) + off` zero-extended to 32 bits, and `valid_o` is high.
- R2: A carry out of bit 19 of the linear sum is dropped: segment FFFF with offset FFFF gives linear 0FFEF.
- R3: With paging on and the selected entry present, the physical address is `{frame, lin[11:0]}`, where the entry index is `lin[19:12]`.
- R4: With paging on and the selected entry not present, the response has `fault_o` high, `valid_o` low and a physical address of zero. `valid_o` and `fault_o` are never high together.
- R5: Each request is answered exactly one cycle later. A cycle with no request is followed by a cycle with `valid_o` and `fault_o` both low.
- R6: A table write takes effect for requests in later cycles. A request in the same cycle as a write to its entry sees the old contents.
- R7: Reset drives `valid_o` and `fault_o` low and marks every table entry not present.
- R8: Two entries may hold the same frame, and both translate to that frame.
- R9: Rewriting an entry, as a new task is loaded, changes the frame used for that linear page.
- R10: With paging off the table is ignored: a page whose entry is not present still translates without a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| seg_i | input | 16 | Segment value |
| off_i | input | 16 | Offset value |
| paging_en_i | input | 1 | Paging enable for this request |
| tbl_we_i | input | 1 | Table entry write strobe |
| tbl_idx_i | input | 8 | Table entry index to write |
| tbl_frame_i | input | 20 | Frame number to write |
| tbl_present_i | input | 1 | Present bit to write |
| phys_addr_o | output | 32 | Translated physical address |
| valid_o | output | 1 | Translation valid |
| fault_o | output | 1 | Page not present fault |

## Verification
A corrupted table entry shows up on the first request that touches that page. It appears one cycle after the request, as a wrong frame in the upper 20 address bits or as a fault where none is expected. The bench therefore keeps its own shadow table and compares every response against it. A broken adder or wrap shows up only for segment and offset pairs whose sum carries across a nibble or past bit 19. For that reason the random traffic is mixed with directed wrap cases. Timing faults between a write and a lookup are caught by a request issued in the very cycle an entry is rewritten.

// File: rtl/v86_pkg.sv
package v86_pkg;
  localparam int unsigned SEG_W     = 16;
  localparam int unsigned OFF_W     = 16;
  localparam int unsigned SEG_SHIFT = 4;
  localparam int unsigned LIN_W     = 20;
  localparam int unsigned PAGE_W    = 12;
  localparam int unsigned PHYS_W    = 32;
  localparam int unsigned VPN_W     = LIN_W - PAGE_W;
  localparam int unsigned FRAME_W   = PHYS_W - PAGE_W;

  typedef struct packed {
    logic               present;
    logic [FRAME_W-1:0] frame;
  } pte_t;
endpackage

// File: rtl/v86_lin_gen.sv
module v86_lin_gen #(
  parameter int unsigned SEG_W     = 16,
  parameter int unsigned OFF_W     = 16,
  parameter int unsigned SEG_SHIFT = 4,
  parameter int unsigned LIN_W     = 20
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [LIN_W-1:0] lin_o
);
  // sum kept at LIN_W bits: carry out of the top bit is dropped (1 MB wrap)
  assign lin_o = LIN_W'({seg_i, {SEG_SHIFT{1'b0}}}) + LIN_W'(off_i);
endmodule

// File: rtl/v86_page_table.sv
module v86_page_table
  import v86_pkg::*;
#(
  parameter int unsigned IDX_W = VPN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  pte_t             wentry_i,
  input  logic [IDX_W-1:0] ridx_i,
  output pte_t             rentry_o
);
  localparam int unsigned ENTRIES = 1 << IDX_W;

  pte_t tbl_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '0;
    end else if (we_i) begin
      tbl_q[widx_i] <= wentry_i;
    end
  end

  // read is combinational: a same-cycle write is seen only from the next cycle
  assign rentry_o = tbl_q[ridx_i];
endmodule

// File: rtl/v86_out_stage.sv
module v86_out_stage
  import v86_pkg::*;
#(
  parameter int unsigned L_W = LIN_W,
  parameter int unsigned P_W = PAGE_W,
  parameter int unsigned A_W = PHYS_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           paging_i,
  input  logic [L_W-1:0] lin_i,
  input  pte_t           pte_i,
  output logic [A_W-1:0] phys_o,
  output logic           valid_o,
  output logic           fault_o
);
  logic [A_W-1:0] phys_d;
  logic           ok_d;

  always_comb begin
    if (!paging_i) begin
      ok_d   = 1'b1;
      phys_d = A_W'(lin_i);
    end else if (pte_i.present) begin
      ok_d   = 1'b1;
      phys_d = A_W'({pte_i.frame, lin_i[P_W-1:0]});
    end else begin
      ok_d   = 1'b0;
      phys_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      fault_o <= 1'b0;
      phys_o  <= '0;
    end else begin
      valid_o <= req_i & ok_d;
      fault_o <= req_i & ~ok_d;
      if (req_i) phys_o <= phys_d;
    end
  end
endmodule

// File: rtl/v86_xlate.sv
module v86_xlate
  import v86_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [SEG_W-1:0]   seg_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic               paging_en_i,
  input  logic               tbl_we_i,
  input  logic [VPN_W-1:0]   tbl_idx_i,
  input  logic [FRAME_W-1:0] tbl_frame_i,
  input  logic               tbl_present_i,
  output logic [PHYS_W-1:0]  phys_addr_o,
  output logic               valid_o,
  output logic               fault_o
);
  logic [LIN_W-1:0] lin;
  pte_t             wentry;
  pte_t             rentry;

  assign wentry.present = tbl_present_i;
  assign wentry.frame   = tbl_frame_i;

  v86_lin_gen #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .LIN_W(LIN_W)
  ) u_lin (
    .seg_i (seg_i),
    .off_i (off_i),
    .lin_o (lin)
  );

  v86_page_table #(.IDX_W(VPN_W)) u_tbl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (tbl_we_i),
    .widx_i   (tbl_idx_i),
    .wentry_i (wentry),
    .ridx_i   (lin[LIN_W-1:PAGE_W]),
    .rentry_o (rentry)
  );

  v86_out_stage #(.L_W(LIN_W), .P_W(PAGE_W), .A_W(PHYS_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_valid_i),
    .paging_i (paging_en_i),
    .lin_i    (lin),
    .pte_i    (rentry),
    .phys_o   (phys_addr_o),
    .valid_o  (valid_o),
    .fault_o  (fault_o)
  );
endmodule

// File: rtl/v86_xlate_chk.sv
module v86_xlate_chk
  import v86_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              paging_en_i,
  input logic [SEG_W-1:0]  seg_i,
  input logic [OFF_W-1:0]  off_i,
  input logic [PHYS_W-1:0] phys_addr_o,
  input logic              valid_o,
  input logic              fault_o
);
  logic [LIN_W-1:0]  lin_ref;
  logic [PAGE_W-1:0] low_ref;

  assign lin_ref = LIN_W'({seg_i, {SEG_SHIFT{1'b0}}}) + LIN_W'(off_i);
  assign low_ref = lin_ref[PAGE_W-1:0];

  p_unpaged_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !paging_en_i |=> valid_o && phys_addr_o == PHYS_W'($past(lin_ref)));

  p_page_offset_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && paging_en_i |=> !valid_o || phys_addr_o[PAGE_W-1:0] == $past(low_ref));

  p_fault_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && fault_o));

  p_fault_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> phys_addr_o == '0);

  p_answer_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> valid_o || fault_o);

  p_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !valid_o && !fault_o);

  p_no_fault_unpaged_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !paging_en_i |=> !fault_o);
endmodule

bind v86_xlate v86_xlate_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .paging_en_i (paging_en_i),
  .seg_i       (seg_i),
  .off_i       (off_i),
  .phys_addr_o (phys_addr_o),
  .valid_o     (valid_o),
  .fault_o     (fault_o)
);

// File: tb/v86_xlate_test.sv
`timescale 1ns/1ps
module v86_xlate_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [15:0] seg_i = '0;
  logic [15:0] off_i = '0;
  logic        paging_en_i = 1'b0;
  logic        tbl_we_i = 1'b0;
  logic [7:0]  tbl_idx_i = '0;
  logic [19:0] tbl_frame_i = '0;
  logic        tbl_present_i = 1'b0;
  logic [31:0] phys_addr_o;
  logic        valid_o;
  logic        fault_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [19:0] m_frame [256];
  bit          m_pres  [256];

  always #10 clk_i = ~clk_i;

  v86_xlate uut (.*);

  function automatic logic [33:0] model(logic [15:0] s, logic [15:0] o, bit pg);
    logic [19:0] lin;
    lin = 20'({s, 4'h0}) + 20'(o);
    if (!pg) return {1'b1, 1'b0, 12'h0, lin};
    if (m_pres[lin[19:12]]) return {1'b1, 1'b0, m_frame[lin[19:12]], lin[11:0]};
    return {1'b0, 1'b1, 32'h0};
  endfunction

  task automatic chk(string tag, logic [33:0] act, logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tx(logic [15:0] s, logic [15:0] o, bit pg, string tag);
    logic [33:0] e;
    e = model(s, o, pg);
    seg_i = s; off_i = o; paging_en_i = pg; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(tag, {valid_o, fault_o, phys_addr_o}, e);
  endtask

  task automatic wr(logic [7:0] idx, logic [19:0] fr, bit pr);
    tbl_we_i = 1'b1; tbl_idx_i = idx; tbl_frame_i = fr; tbl_present_i = pr;
    @(negedge clk_i);
    tbl_we_i = 1'b0;
    m_frame[idx] = fr; m_pres[idx] = pr;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1b3d));
    for (int i = 0; i < 256; i++) begin m_frame[i] = '0; m_pres[i] = 1'b0; end
    @(negedge clk_i);
    chk("R7 reset outputs", {valid_o, fault_o, 32'h0}, 34'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R7: every entry starts not present
    tx(16'h0000, 16'h0000, 1'b1, "R7 entry 00 not present");
    tx(16'hFFFF, 16'h000F, 1'b1, "R7 entry FF not present");
    tx(16'h1230, 16'h0456, 1'b1, "R7 mid entry not present");

    // R1 / R2 directed
    tx(16'h1234, 16'h5678, 1'b0, "R1 unpaged 1234:5678");
    tx(16'hFFFF, 16'hFFFF, 1'b0, "R2 wrap FFFF:FFFF");
    tx(16'hF000, 16'hFFFF, 1'b0, "R2 top of 1MB");
    tx(16'hF800, 16'h8000, 1'b0, "R2 wrap to zero");

    // R5 idle
    @(negedge clk_i);
    chk("R5 idle cycle", {valid_o, fault_o, 32'h0}, 34'h0);

    // R3 / R9 / R8
    wr(8'h12, 20'hABCDE, 1'b1);
    tx(16'h1200, 16'h0345, 1'b1, "R3 mapped page 12");
    wr(8'h12, 20'h00777, 1'b1);
    tx(16'h1200, 16'h0345, 1'b1, "R9 remapped page 12");
    wr(8'h03, 20'h55555, 1'b1);
    wr(8'h07, 20'h55555, 1'b1);
    tx(16'h0300, 16'h0ABC, 1'b1, "R8 shared frame via 03");
    tx(16'h0700, 16'h0ABC, 1'b1, "R8 shared frame via 07");
    wr(8'hFF, 20'hFFFFF, 1'b1);
    tx(16'hFFFF, 16'h000F, 1'b1, "R3 top page top frame");

    // R4 cleared present bit
    wr(8'h07, 20'h12345, 1'b0);
    tx(16'h0700, 16'h0001, 1'b1, "R4 cleared entry faults");
    // R10 paging off ignores absent entry
    tx(16'h0700, 16'h0001, 1'b0, "R10 unpaged ignores table");

    // R6 same-cycle write and lookup
    begin
      logic [33:0] e;
      e = model(16'h1200, 16'h0010, 1'b1);
      tbl_we_i = 1'b1; tbl_idx_i = 8'h12; tbl_frame_i = 20'h9999A; tbl_present_i = 1'b1;
      seg_i = 16'h1200; off_i = 16'h0010; paging_en_i = 1'b1; req_valid_i = 1'b1;
      @(negedge clk_i);
      tbl_we_i = 1'b0; req_valid_i = 1'b0;
      m_frame[8'h12] = 20'h9999A; m_pres[8'h12] = 1'b1;
      chk("R6 same-cycle sees old entry", {valid_o, fault_o, phys_addr_o}, e);
      tx(16'h1200, 16'h0010, 1'b1, "R6 next cycle sees new entry");
    end

    // random traffic
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(0, 3) == 0)
        wr(8'($urandom), 20'($urandom), $urandom_range(0, 3) != 0);
      tx(16'($urandom), 16'($urandom), 1'($urandom), "R1/R3/R4 random");
      if ($urandom_range(0, 7) == 0) begin
        @(negedge clk_i);
        chk("R5 random idle", {valid_o, fault_o, 32'h0}, 34'h0);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule